// File: doc/BRIEF.md
# Serially Programmed Two-Plane Logic Array

This block is a small programmable logic array. It evaluates any set of sum-of-products functions of its inputs without a clock. A programmable AND plane forms product terms from the inputs. Each input enters a term as its true value or its complement, or it stays out of the term. A programmable OR plane collects product terms onto each output. One product term can feed any number of outputs. A final per-output bit chooses between the plain sum and its inverse, so each function can be built from whichever of its true or complemented form needs fewer product terms.

The configuration is written one bit per clock into a shadow register. It is applied in one step when the commit strobe arrives, so the outputs never show a partly loaded array. The number of inputs, product terms and outputs are parameters.

Top module: `pla_eval`

## Requirements
- R1: While reset is low, and after it until the first commit, the active configuration is all zeros, and every output reads 0 for every input value.
- R2: The literal code for term t and input i is at active-configuration bits [A+2*(t*N_IN+i)+1 : A+2*(t*N_IN+i)], where A = N_OUT + N_TERM*N_OUT. Code 2'b10 passes the input true, 2'b01 passes it complemented, and 2'b00 leaves it out of the term.
- R3: Literal code 2'b11 forces its product term to 0 for every input value.
- R4: A product term whose literals are all 2'b00 evaluates to 1. An output with no product term connected has a sum of 0, so it reads its polarity bit.
- R5: Output o is the OR of the product terms t whose bit N_OUT + o*N_TERM + t is 1. One product term may feed several outputs.
- R6: Polarity bit o (active bit o) set to 1 inverts output o (AND-OR-INVERT). Set to 0, it gives the plain AND-OR value.
- R7: On each clock with cfg_shift high, cfg_bit enters bit 0 of the shadow register and the older bits move up one place. The configuration is therefore sent most significant bit first: AND plane, then OR plane, then the polarity bits, with polarity bit 0 last.
- R8: Shifting does not change the outputs. They follow the previously committed configuration until the commit.
- R9: On a clock edge with cfg_commit high, the active configuration takes the shadow value held before that edge. The outputs follow the new configuration from that edge on.
- R10: The outputs respond to a change on x_in in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift cfg_bit into the shadow register |
| cfg_commit | input | 1 | Copy the shadow register into the active configuration |
| x_in | input | N_IN | Logic inputs |
| f_out | output | N_OUT | Evaluated outputs |

## Verification
The bench uses the default sizing: 4 inputs, 5 product terms and 2 outputs, which gives a 52-bit configuration. This sizing is enough to load a two-function array in which one product term is shared between the outputs and one output is inverted. Both functions are checked against their minterm lists over all 16 input values. Further configurations cover the forced-zero literal code, a term with every input left out and outputs with no terms connected. The outputs are also checked in the middle of a serial load and on both sides of the commit edge.

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bit,
  input  logic              cfg_shift,
  input  logic              cfg_commit,
  input  logic [N_IN-1:0]   x_in,
  output logic [N_OUT-1:0]  f_out
);
  localparam int AND_W  = 2 * N_IN * N_TERM;
  localparam int OR_W   = N_TERM * N_OUT;
  localparam int CFG_W  = AND_W + OR_W + N_OUT;
  localparam int OR_LO  = N_OUT;
  localparam int AND_LO = N_OUT + OR_W;

  logic [CFG_W-1:0]  shadow, active;
  logic [N_TERM-1:0] term;

  always_ff @(posedge clk) begin
    if (!rst_n)         shadow <= '0;
    else if (cfg_shift) shadow <= {shadow[CFG_W-2:0], cfg_bit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          active <= '0;
    else if (cfg_commit) active <= shadow;
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> active == '0);
  p_hold_r8:   assert property (@(posedge clk) disable iff (!rst_n) !cfg_commit |=> $stable(active));
  p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n) cfg_commit |=> active == $past(shadow));
  p_shift_r7:  assert property (@(posedge clk) disable iff (!rst_n) cfg_shift |=> shadow[0] == $past(cfg_bit));

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] hit;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic [1:0] code;
      assign code   = active[AND_LO + 2*(t*N_IN + i) +: 2];
      assign hit[i] = (code == 2'b00) | ((code == 2'b10) & x_in[i]) | ((code == 2'b01) & ~x_in[i]);
      p_kill_r3: assert property (@(posedge clk) disable iff (!rst_n) (code == 2'b11) |-> !term[t]);
    end
    assign term[t] = &hit;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] row;
    assign row      = active[OR_LO + o*N_TERM +: N_TERM];
    assign f_out[o] = (|(term & row)) ^ active[o];
    p_empty_row_r4: assert property (@(posedge clk) disable iff (!rst_n) (row == '0) |-> f_out[o] == active[o]);
  end
endmodule

// File: tb/pla_eval_bench.sv
module pla_eval_bench;
  localparam int N_IN = 4, N_TERM = 5, N_OUT = 2;
  localparam int OR_W = N_TERM * N_OUT;
  localparam int CFG_W = 2*N_IN*N_TERM + OR_W + N_OUT;
  localparam int A = N_OUT + OR_W;

  logic clk = 0, rst_n = 0, cfg_bit = 0, cfg_shift = 0, cfg_commit = 0;
  logic [N_IN-1:0]  x_in = '0;
  logic [N_OUT-1:0] f_out;
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit shq[$];
  bit [CFG_W-1:0] ref_act, img;

  always #10 clk = ~clk;

  pla_eval #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_pla_eval (
    .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_bit), .cfg_shift(cfg_shift),
    .cfg_commit(cfg_commit), .x_in(x_in), .f_out(f_out));

  function automatic bit [N_OUT-1:0] model(bit [CFG_W-1:0] c, bit [N_IN-1:0] x);
    bit [N_OUT-1:0] r;
    for (int o = 0; o < N_OUT; o++) begin
      bit s = 0;
      for (int t = 0; t < N_TERM; t++) begin
        bit p = 1;
        for (int i = 0; i < N_IN; i++) begin
          int k = A + 2*(t*N_IN + i);
          bit [1:0] cd = {c[k+1], c[k]};
          if (cd == 2'b11 || (cd == 2'b10 && !x[i]) || (cd == 2'b01 && x[i])) p = 0;
        end
        if (c[N_OUT + o*N_TERM + t] && p) s = 1;
      end
      r[o] = s ^ c[o];
    end
    return r;
  endfunction

  task automatic check(string req, logic [N_OUT-1:0] got, logic [N_OUT-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: f_out=%b expected %b (x_in=%b) at %0t", req, got, exp, x_in, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      shq.delete();
      for (int j = 0; j < CFG_W; j++) shq.push_back(1'b0);
      ref_act = '0;
    end else begin
      if (cfg_commit) for (int j = 0; j < CFG_W; j++) ref_act[j] = shq[CFG_W-1-j];
      if (cfg_shift) begin
        shq.push_back(cfg_bit);
        void'(shq.pop_front());
      end
    end
  end

  always @(negedge clk) check(cur_req, f_out, model(ref_act, x_in));

  task automatic set_lit(int t, int i, bit [1:0] cd);
    img[A + 2*(t*N_IN + i) +: 2] = cd;
  endtask
  task automatic set_or(int o, int t); img[N_OUT + o*N_TERM + t] = 1'b1; endtask

  task automatic shift_in(int stop_at);
    for (int j = CFG_W-1; j >= stop_at; j--) begin
      @(posedge clk); #2 cfg_shift = 1; cfg_bit = img[j];
    end
    @(posedge clk); #2 cfg_shift = 0;
  endtask

  task automatic commit();
    @(posedge clk); #2 cfg_commit = 1;
    @(posedge clk); #2 cfg_commit = 0;
  endtask

  task automatic sweep(string req, bit [15:0] m0, bit [15:0] m1);
    for (int v = 0; v < 16; v++) begin
      x_in = v[3:0];
      #1 check(req, f_out, {m1[v], m0[v]});
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    for (int v = 0; v < 16; v += 5) begin x_in = v[3:0]; #1 check("R1", f_out, 2'b00); end
    rst_n = 1;
    @(negedge clk);
    check("R1", f_out, 2'b00);

    // inputs w,x,y,z = x_in[3..0]
    cur_req = "R2";
    img = '0;
    set_lit(0,3,2'b01); set_lit(0,1,2'b01); set_lit(0,0,2'b01);
    set_lit(1,3,2'b01); set_lit(1,2,2'b10); set_lit(1,0,2'b10);
    set_lit(2,3,2'b10); set_lit(2,2,2'b01); set_lit(2,1,2'b01); set_lit(2,0,2'b10);
    set_lit(3,3,2'b01); set_lit(3,2,2'b10);
    set_lit(4,3,2'b01); set_lit(4,1,2'b10); set_lit(4,0,2'b10);
    set_or(0,0); set_or(0,1); set_or(0,2);
    set_or(1,2); set_or(1,3); set_or(1,4);
    img[1] = 1'b1;
    shift_in(0);
    @(negedge clk); x_in = 4'd5; #1 check("R9", f_out, 2'b00);
    commit();
    @(negedge clk); #1 check("R9", f_out, 2'b01);
    // R5/R6: shared term 2, output 1 inverted
    sweep("R5", 16'h02B1, 16'hFD07);
    x_in = 4'd0; #1 check("R10", f_out, 2'b11);
    x_in = 4'd9; #1 check("R10", f_out, 2'b01);
    x_in = 4'd6; #1 check("R6", f_out, 2'b00);

    cur_req = "R8";
    img = '0;
    set_lit(1,2,2'b11); set_lit(1,0,2'b10);
    set_or(0,0); set_or(1,1);
    shift_in(20);
    x_in = 4'd5; #1 check("R8", f_out, 2'b01);
    x_in = 4'd0; #1 check("R8", f_out, 2'b11);
    shift_in(0);
    @(negedge clk); #1 check("R8", f_out, 2'b11);
    commit();
    cur_req = "R3";
    sweep("R3", 16'hFFFF, 16'h0000);

    cur_req = "R4";
    img = '0;
    img[1] = 1'b1;
    shift_in(0);
    commit();
    sweep("R4", 16'h0000, 16'hFFFF);

    cur_req = "R7";
    img = '0;
    set_lit(4,3,2'b10); set_or(0,4); img[0] = 1'b1;
    shift_in(0);
    commit();
    sweep("R7", 16'h00FF, 16'h0000);

    cur_req = "R1";
    @(posedge clk); #2 rst_n = 0;
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk); x_in = 4'd15; #1 check("R1", f_out, 2'b00);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule